// File: doc/BRIEF.md
# Wrapping Indirect Register Pointer Pair

This block holds two independent 9-bit indirect address pointers, A and B, that supply register-file addresses for instruction operands. An access can leave a pointer alone or move it by one step on every clock. Both pointers can be stepped in the same cycle, so a multiply-accumulate loop can fetch one operand through each pointer on every clock with no extra cycles.

Each pointer runs in one of two ranges. In the full range it covers the whole 512-entry space and rolls over at either end. In the window range it is held between a programmed bottom and top address. Stepping up past the top returns it to the bottom, and stepping down past the bottom returns it to the top. Because the wrap costs no cycles, a circular sample buffer or coefficient table can be swept continuously.

A pointer is configured by commands. An immediate load takes effect on the next cycle. A fix command opens a window and places the pointer at its bottom. A late load models a value that comes from a register: it takes effect only after two further access slots, and those slots still see the old pointer.

Each pointer is controlled by two small state machines:

- The range machine has two states, RANGE_FULL and RANGE_WINDOW.
  - A fix command moves it to RANGE_WINDOW.
  - An immediate load, or the landing of a late load, moves it back to RANGE_FULL.
- The late-load machine has two states, LATE_IDLE and LATE_WAIT.
  - A late-load command moves it to LATE_WAIT.
  - When the gap count runs out, the pending value lands and the machine returns to LATE_IDLE.
  - An immediate load or a fix command also returns it to LATE_IDLE, which cancels the pending value.

Top module: `wix_pair`

## Requirements
- R1: After reset, both pointers are 0x000 and both are in the full range.
- R2: The access mode codes are 00 keep, 01 post-increment, 10 post-decrement and 11 pre-increment. With the access enable high, keep, post-increment and post-decrement present the current pointer, and pre-increment presents the stepped address. With the enable low, the current pointer is presented and does not change.
- R3: In the full range, stepping up from 0x1FF gives 0x000 and stepping down from 0x000 gives 0x1FF.
- R4: Command code 01 (immediate load) sets the pointer to the command value on the next cycle and selects the full range.
- R5: Command code 11 (fix) stores the command value as the window bottom and the top input as the window top. It places the pointer at the bottom on the next cycle and selects the window range.
- R6: In the window range, stepping up from the top gives the bottom and stepping down from the bottom gives the top. Both wraps take no extra cycle, and the pointer stays between bottom and top.
- R7: When the window bottom equals the window top, every access mode leaves the pointer unchanged.
- R8: Command code 10 (late load) lets the accesses in the two following slots see and step the old pointer. The value is present from the third cycle on, in the full range. An immediate load or a fix issued during the gap cancels the pending value.
- R9: The two pointers update independently. Both can be stepped on every clock in the same cycle.
- R10: When a command and an access fall in the same cycle, the access presents an address derived from the current pointer, and the command's value overrides the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en_a | input | 1 | Pointer A access this cycle |
| acc_mode_a | input | 2 | Pointer A access mode |
| cmd_a | input | 2 | Pointer A command (00 none) |
| cmd_val_a | input | 9 | Pointer A load value or window bottom |
| cmd_top_a | input | 9 | Pointer A window top for a fix command |
| addr_a | output | 9 | Pointer A effective address |
| acc_en_b | input | 1 | Pointer B access this cycle |
| acc_mode_b | input | 2 | Pointer B access mode |
| cmd_b | input | 2 | Pointer B command (00 none) |
| cmd_val_b | input | 9 | Pointer B load value or window bottom |
| cmd_top_b | input | 9 | Pointer B window top for a fix command |
| addr_b | output | 9 | Pointer B effective address |

## Verification
The window-containment property assumes that every fix command gives a bottom no greater than its top, and it is guarded so that it only checks ordered windows. The stepping properties only consider cycles with no command and no late load landing, since a load legitimately overrides the step. The late-load property applies to the default two-slot gap and assumes that no other command is issued in those slots. The directed tasks always open ordered windows and leave the gap slots free of commands, except in the one case that tests cancellation on purpose.

// File: rtl/wix_pkg.sv
package wix_pkg;

    localparam int unsigned WIX_AW  = 9;
    localparam int unsigned WIX_GAP = 2;

    typedef enum logic [1:0] {
        UPD_KEEP     = 2'b00,
        UPD_POST_INC = 2'b01,
        UPD_POST_DEC = 2'b10,
        UPD_PRE_INC  = 2'b11
    } upd_mode_e;

    typedef enum logic [1:0] {
        CMD_IDLE      = 2'b00,
        CMD_LOAD_NOW  = 2'b01,
        CMD_LOAD_LATE = 2'b10,
        CMD_FIX_WIN   = 2'b11
    } ptr_cmd_e;

    typedef enum logic {
        RANGE_FULL   = 1'b0,
        RANGE_WINDOW = 1'b1
    } range_e;

    typedef enum logic {
        LATE_IDLE = 1'b0,
        LATE_WAIT = 1'b1
    } late_e;

endpackage

// File: rtl/wix_step.sv
module wix_step #(
    parameter int unsigned AW = 9
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] top,
    input  logic          win,
    output logic [AW-1:0] ptr_up,
    output logic [AW-1:0] ptr_dn
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        if (win && (base == top)) begin
            ptr_up = ptr;
            ptr_dn = ptr;
        end else if (win) begin
            ptr_up = (ptr == top)  ? base : ptr + ONE;
            ptr_dn = (ptr == base) ? top  : ptr - ONE;
        end else begin
            ptr_up = ptr + ONE;
            ptr_dn = ptr - ONE;
        end
    end
endmodule

// File: rtl/wix_channel.sv
module wix_channel
    import wix_pkg::*;
#(
    parameter int unsigned AW  = 9,
    parameter int unsigned GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [1:0]    acc_mode,
    input  logic [1:0]    cmd,
    input  logic [AW-1:0] cmd_val,
    input  logic [AW-1:0] cmd_top,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] ptr_o,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] top_o,
    output logic          win_o,
    output logic          land_o
);
    localparam int unsigned CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic [AW-1:0] ptr_q,  ptr_d;
    logic [AW-1:0] base_q, base_d;
    logic [AW-1:0] top_q,  top_d;
    logic [AW-1:0] pend_q, pend_d;
    logic [CW-1:0] cnt_q,  cnt_d;
    range_e        range_q, range_d;
    late_e         late_q,  late_d;
    logic [AW-1:0] ptr_up, ptr_dn;
    logic          land;
    upd_mode_e     mode;
    ptr_cmd_e      op;

    assign mode = upd_mode_e'(acc_mode);
    assign op   = ptr_cmd_e'(cmd);
    assign land = (late_q == LATE_WAIT) && (cnt_q == LAST);

    wix_step #(.AW(AW)) u_step (
        .ptr    (ptr_q),
        .base   (base_q),
        .top    (top_q),
        .win    (range_q == RANGE_WINDOW),
        .ptr_up (ptr_up),
        .ptr_dn (ptr_dn)
    );

    // next-state logic
    always_comb begin
        ptr_d   = ptr_q;
        base_d  = base_q;
        top_d   = top_q;
        pend_d  = pend_q;
        cnt_d   = cnt_q;
        range_d = range_q;
        late_d  = late_q;

        if (acc_en) begin
            unique case (mode)
                UPD_KEEP:     ptr_d = ptr_q;
                UPD_POST_INC: ptr_d = ptr_up;
                UPD_PRE_INC:  ptr_d = ptr_up;
                UPD_POST_DEC: ptr_d = ptr_dn;
            endcase
        end

        unique case (late_q)
            LATE_IDLE: ;
            LATE_WAIT: begin
                if (land) begin
                    ptr_d   = pend_q;
                    range_d = RANGE_FULL;
                    late_d  = LATE_IDLE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase

        unique case (op)
            CMD_IDLE: ;
            CMD_LOAD_NOW: begin
                ptr_d   = cmd_val;
                range_d = RANGE_FULL;
                late_d  = LATE_IDLE;
            end
            CMD_LOAD_LATE: begin
                pend_d = cmd_val;
                cnt_d  = '0;
                late_d = LATE_WAIT;
            end
            CMD_FIX_WIN: begin
                base_d  = cmd_val;
                top_d   = cmd_top;
                ptr_d   = cmd_val;
                range_d = RANGE_WINDOW;
                late_d  = LATE_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            base_q  <= '0;
            top_q   <= '0;
            pend_q  <= '0;
            cnt_q   <= '0;
            range_q <= RANGE_FULL;
            late_q  <= LATE_IDLE;
        end else begin
            ptr_q   <= ptr_d;
            base_q  <= base_d;
            top_q   <= top_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
            range_q <= range_d;
            late_q  <= late_d;
        end
    end

    // outputs
    always_comb begin
        addr   = (acc_en && (mode == UPD_PRE_INC)) ? ptr_up : ptr_q;
        ptr_o  = ptr_q;
        base_o = base_q;
        top_o  = top_q;
        win_o  = (range_q == RANGE_WINDOW);
        land_o = land;
    end
endmodule

// File: rtl/wix_pair.sv
module wix_pair #(
    parameter int unsigned AW  = wix_pkg::WIX_AW,
    parameter int unsigned GAP = wix_pkg::WIX_GAP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en_a,
    input  logic [1:0]    acc_mode_a,
    input  logic [1:0]    cmd_a,
    input  logic [AW-1:0] cmd_val_a,
    input  logic [AW-1:0] cmd_top_a,
    output logic [AW-1:0] addr_a,
    input  logic          acc_en_b,
    input  logic [1:0]    acc_mode_b,
    input  logic [1:0]    cmd_b,
    input  logic [AW-1:0] cmd_val_b,
    input  logic [AW-1:0] cmd_top_b,
    output logic [AW-1:0] addr_b
);
    localparam int unsigned NPTR = 2;

    logic          en_v   [NPTR];
    logic [1:0]    mode_v [NPTR];
    logic [1:0]    cmd_v  [NPTR];
    logic [AW-1:0] val_v  [NPTR];
    logic [AW-1:0] topi_v [NPTR];
    logic [AW-1:0] addr_v [NPTR];
    logic [AW-1:0] ptr_v  [NPTR];
    logic [AW-1:0] base_v [NPTR];
    logic [AW-1:0] top_v  [NPTR];
    logic          win_v  [NPTR];
    logic          land_v [NPTR];

    assign en_v[0]   = acc_en_a;
    assign mode_v[0] = acc_mode_a;
    assign cmd_v[0]  = cmd_a;
    assign val_v[0]  = cmd_val_a;
    assign topi_v[0] = cmd_top_a;
    assign en_v[1]   = acc_en_b;
    assign mode_v[1] = acc_mode_b;
    assign cmd_v[1]  = cmd_b;
    assign val_v[1]  = cmd_val_b;
    assign topi_v[1] = cmd_top_b;
    assign addr_a    = addr_v[0];
    assign addr_b    = addr_v[1];

    for (genvar g = 0; g < NPTR; g++) begin : g_ch
        wix_channel #(.AW(AW), .GAP(GAP)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_en   (en_v[g]),
            .acc_mode (mode_v[g]),
            .cmd      (cmd_v[g]),
            .cmd_val  (val_v[g]),
            .cmd_top  (topi_v[g]),
            .addr     (addr_v[g]),
            .ptr_o    (ptr_v[g]),
            .base_o   (base_v[g]),
            .top_o    (top_v[g]),
            .win_o    (win_v[g]),
            .land_o   (land_v[g])
        );
    end
endmodule

// File: rtl/wix_pair_chk.sv
module wix_pair_chk #(
    parameter int unsigned AW  = 9,
    parameter int unsigned GAP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_a,
    input logic [1:0]    mode_a,
    input logic [1:0]    cmd_a,
    input logic [AW-1:0] val_a,
    input logic [AW-1:0] addr_a,
    input logic [AW-1:0] ptr_a,
    input logic [AW-1:0] base_a,
    input logic [AW-1:0] top_a,
    input logic          win_a,
    input logic          land_a,
    input logic          en_b,
    input logic [1:0]    mode_b,
    input logic [1:0]    cmd_b,
    input logic [AW-1:0] addr_b,
    input logic [AW-1:0] ptr_b,
    input logic [AW-1:0] base_b,
    input logic [AW-1:0] top_b,
    input logic          win_b,
    input logic          land_b
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr_a == '0) && (ptr_b == '0) && !win_a && !win_b); // R1

    AST_PREINC_NEXT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && mode_a == 2'b11 && cmd_a == 2'b00 && !land_a) |=> ptr_a == $past(addr_a)); // R2

    AST_PREINC_NEXT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (en_b && mode_b == 2'b11 && cmd_b == 2'b00 && !land_b) |=> ptr_b == $past(addr_b)); // R9

    AST_FULL_UP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && mode_a == 2'b01 && cmd_a == 2'b00 && !land_a && !win_a)
        |=> ptr_a == AW'($past(ptr_a) + AW'(1))); // R3

    AST_FULL_DOWN_B: assert property (@(posedge clk) disable iff (!rst_n)
        (en_b && mode_b == 2'b10 && cmd_b == 2'b00 && !land_b && !win_b)
        |=> ptr_b == AW'($past(ptr_b) - AW'(1))); // R3

    AST_LOAD_NOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a == 2'b01) |=> (ptr_a == $past(val_a)) && !win_a); // R4

    AST_FIX_BASE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a == 2'b11) |=> (ptr_a == $past(val_a)) && (base_a == $past(val_a)) && win_a); // R5

    AST_WINDOW_BOUND_A: assert property (@(posedge clk) disable iff (!rst_n)
        (win_a && base_a <= top_a) |-> (ptr_a >= base_a) && (ptr_a <= top_a)); // R6

    AST_WINDOW_BOUND_B: assert property (@(posedge clk) disable iff (!rst_n)
        (win_b && base_b <= top_b) |-> (ptr_b >= base_b) && (ptr_b <= top_b)); // R6

    AST_FLAT_WINDOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (win_a && base_a == top_a && en_a && cmd_a == 2'b00 && !land_a) |=> $stable(ptr_a)); // R7

    if (GAP == 2) begin : g_late
        AST_LATE_LAND_A: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && $past(cmd_a, 3) == 2'b10 && $past(cmd_a, 2) == 2'b00
             && $past(cmd_a, 1) == 2'b00) |-> (ptr_a == $past(val_a, 3)) && !win_a); // R8
    end
endmodule

bind wix_pair wix_pair_chk #(.AW(AW), .GAP(GAP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_a   (acc_en_a),
    .mode_a (acc_mode_a),
    .cmd_a  (cmd_a),
    .val_a  (cmd_val_a),
    .addr_a (addr_a),
    .ptr_a  (ptr_v[0]),
    .base_a (base_v[0]),
    .top_a  (top_v[0]),
    .win_a  (win_v[0]),
    .land_a (land_v[0]),
    .en_b   (acc_en_b),
    .mode_b (acc_mode_b),
    .cmd_b  (cmd_b),
    .addr_b (addr_b),
    .ptr_b  (ptr_v[1]),
    .base_b (base_v[1]),
    .top_b  (top_v[1]),
    .win_b  (win_v[1]),
    .land_b (land_v[1])
);

// File: tb/wix_pair_test.sv
module wix_pair_test;
    localparam logic [1:0] M_KEEP = 2'b00, M_PINC = 2'b01, M_PDEC = 2'b10, M_PRE = 2'b11;
    localparam logic [1:0] C_NONE = 2'b00, C_NOW = 2'b01, C_LATE = 2'b10, C_FIX = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en_a = 1'b0, acc_en_b = 1'b0;
    logic [1:0] acc_mode_a = '0, acc_mode_b = '0;
    logic [1:0] cmd_a = '0, cmd_b = '0;
    logic [8:0] cmd_val_a = '0, cmd_top_a = '0, cmd_val_b = '0, cmd_top_b = '0;
    logic [8:0] addr_a, addr_b;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wix_pair uut (
        .clk(clk), .rst_n(rst_n),
        .acc_en_a(acc_en_a), .acc_mode_a(acc_mode_a), .cmd_a(cmd_a),
        .cmd_val_a(cmd_val_a), .cmd_top_a(cmd_top_a), .addr_a(addr_a),
        .acc_en_b(acc_en_b), .acc_mode_b(acc_mode_b), .cmd_b(cmd_b),
        .cmd_val_b(cmd_val_b), .cmd_top_b(cmd_top_b), .addr_b(addr_b)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one slot for both pointers: drive after a falling edge, sample, advance
    task automatic step_ab(
        input logic ea, input logic [1:0] ma, input logic [1:0] ca,
        input logic [8:0] va, input logic [8:0] ta, input logic [8:0] xa, input bit ka,
        input logic eb, input logic [1:0] mb, input logic [1:0] cb,
        input logic [8:0] vb, input logic [8:0] tb, input logic [8:0] xb, input bit kb,
        input string tag);
        acc_en_a = ea; acc_mode_a = ma; cmd_a = ca; cmd_val_a = va; cmd_top_a = ta;
        acc_en_b = eb; acc_mode_b = mb; cmd_b = cb; cmd_val_b = vb; cmd_top_b = tb;
        #1;
        if (ka) chk({tag, " (A)"}, addr_a, xa);
        if (kb) chk({tag, " (B)"}, addr_b, xb);
        @(negedge clk);
        acc_en_a = 1'b0; acc_mode_a = '0; cmd_a = '0;
        acc_en_b = 1'b0; acc_mode_b = '0; cmd_b = '0;
    endtask

    task automatic step_a(input logic e, input logic [1:0] m, input logic [1:0] c,
                          input logic [8:0] v, input logic [8:0] t, input logic [8:0] x,
                          input bit k, input string tag);
        step_ab(e, m, c, v, t, x, k, 1'b0, M_KEEP, C_NONE, '0, '0, '0, 1'b0, tag);
    endtask

    task automatic step_b(input logic e, input logic [1:0] m, input logic [1:0] c,
                          input logic [8:0] v, input logic [8:0] t, input logic [8:0] x,
                          input bit k, input string tag);
        step_ab(1'b0, M_KEEP, C_NONE, '0, '0, '0, 1'b0, e, m, c, v, t, x, k, tag);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 pointer A clear after reset", addr_a, 9'h000);
        chk("R1 pointer B clear after reset", addr_b, 9'h000);
        @(negedge clk);
        step_a(1, M_PDEC, C_NONE, 0, 0, 9'h000, 1, "R1 full range at reset, step down");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h1FF, 1, "R1 full range at reset, wrapped");
    endtask

    task automatic t_modes;
        step_a(0, M_KEEP, C_NOW, 9'h010, 0, 0, 0, "");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h010, 1, "R2 post-inc shows old");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h011, 1, "R2 post-inc stepped");
        step_a(1, M_PRE,  C_NONE, 0, 0, 9'h012, 1, "R2 pre-inc shows new");
        step_a(1, M_PDEC, C_NONE, 0, 0, 9'h012, 1, "R2 post-dec shows old");
        step_a(1, M_KEEP, C_NONE, 0, 0, 9'h011, 1, "R2 keep shows current");
        step_a(0, M_PINC, C_NONE, 0, 0, 9'h011, 1, "R2 disabled access");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h011, 1, "R2 disabled access no change");
    endtask

    task automatic t_fullwrap;
        step_a(0, M_KEEP, C_NOW, 9'h1FF, 0, 0, 0, "");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h1FF, 1, "R3 step up at top");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h000, 1, "R3 rolled to zero");
        step_b(0, M_KEEP, C_NOW, 9'h000, 0, 0, 0, "");
        step_b(1, M_PDEC, C_NONE, 0, 0, 9'h000, 1, "R3 step down at zero");
        step_b(0, M_KEEP, C_NONE, 0, 0, 9'h1FF, 1, "R3 rolled to top");
    endtask

    task automatic t_load;
        step_b(0, M_KEEP, C_NOW, 9'h0AB, 0, 0, 0, "");
        step_b(0, M_KEEP, C_NONE, 0, 0, 9'h0AB, 1, "R4 immediate load");
        step_a(0, M_KEEP, C_FIX, 9'h020, 9'h023, 0, 0, "");
        step_a(0, M_KEEP, C_NOW, 9'h023, 0, 0, 0, "");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h023, 1, "R4 load value");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h024, 1, "R4 load leaves window");
    endtask

    task automatic t_window;
        step_a(0, M_KEEP, C_FIX, 9'h020, 9'h023, 0, 0, "");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h020, 1, "R5 fix places pointer at bottom");
        for (int i = 0; i < 4; i++)
            step_a(1, M_PINC, C_NONE, 0, 0, 9'(9'h020 + i), 1, "R6 sweep window");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h020, 1, "R6 top wraps to bottom");
        step_a(1, M_PDEC, C_NONE, 0, 0, 9'h020, 1, "R6 step down at bottom");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h023, 1, "R6 bottom wraps to top");
        step_a(1, M_PRE,  C_NONE, 0, 0, 9'h020, 1, "R6 pre-inc wraps");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h020, 1, "R6 pre-inc stored");
    endtask

    task automatic t_flat;
        step_a(0, M_KEEP, C_FIX, 9'h055, 9'h055, 0, 0, "");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h055, 1, "R7 flat post-inc");
        step_a(1, M_PDEC, C_NONE, 0, 0, 9'h055, 1, "R7 flat post-dec");
        step_a(1, M_PRE,  C_NONE, 0, 0, 9'h055, 1, "R7 flat pre-inc");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h055, 1, "R7 flat unchanged");
    endtask

    task automatic t_late;
        step_a(0, M_KEEP, C_FIX, 9'h020, 9'h023, 0, 0, "");
        step_a(1, M_PINC, C_LATE, 9'h1FF, 0, 9'h020, 1, "R8 issue slot sees old");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h021, 1, "R8 gap slot 1 sees old");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h022, 1, "R8 gap slot 2 sees old");
        step_a(1, M_PINC, C_NONE, 0, 0, 9'h1FF, 1, "R8 late value landed");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h000, 1, "R8 full range after landing");
        step_a(0, M_KEEP, C_LATE, 9'h080, 0, 0, 0, "");
        step_a(0, M_KEEP, C_NOW, 9'h040, 0, 0, 0, "");
        for (int i = 0; i < 3; i++)
            step_a(0, M_KEEP, C_NONE, 0, 0, 9'h040, 1, "R8 cancelled late load");
    endtask

    task automatic t_dual;
        step_ab(0, M_KEEP, C_FIX, 9'h000, 9'h007, 0, 0,
                0, M_KEEP, C_NOW, 9'h100, 0, 0, 0, "");
        for (int i = 0; i < 16; i++)
            step_ab(1, M_PINC, C_NONE, 0, 0, 9'(i % 8), 1,
                    1, M_PINC, C_NONE, 0, 0, 9'(9'h100 + i), 1, "R9 both stepping every clock");
        for (int i = 0; i < 4; i++)
            step_ab(1, M_PDEC, C_NONE, 0, 0, 9'((8 - i) % 8), 1,
                    1, M_PRE, C_NONE, 0, 0, 9'(9'h111 + i), 1, "R9 opposite directions");
    endtask

    task automatic t_collide;
        step_a(0, M_KEEP, C_NOW, 9'h040, 0, 0, 0, "");
        step_a(1, M_PINC, C_NOW, 9'h090, 0, 9'h040, 1, "R10 access uses current pointer");
        step_a(0, M_KEEP, C_NONE, 0, 0, 9'h090, 1, "R10 load overrides step");
        step_b(0, M_KEEP, C_NOW, 9'h010, 0, 0, 0, "");
        step_b(1, M_PRE, C_FIX, 9'h030, 9'h031, 9'h011, 1, "R10 pre-inc with fix");
        step_b(0, M_KEEP, C_NONE, 0, 0, 9'h030, 1, "R10 fix overrides step");
    endtask

    initial begin
        t_reset();
        t_modes();
        t_fullwrap();
        t_load();
        t_window();
        t_flat();
        t_late();
        t_dual();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule